// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor Core

This block is a minimal processor whose only operation is "subtract, store, and branch if the result is negative." Each instruction takes three consecutive words in memory: a destination operand address, a source operand address and a branch target. The core reads both operands and subtracts the source from the destination. It writes the 16-bit difference back into the destination word. If the difference is negative it jumps to the target; otherwise it steps to the next instruction.

Code and data share one internal word-addressed memory. A test-only write port loads that memory while the core is idle, and a test-only read port lets a bench inspect it. A pulse on the run input starts execution at the reset PC. A multi-cycle sequencer steps through each instruction with no opcode decoding. It fetches three words, reads both operands, writes the result and then updates the PC, spending one clock on each step. A taken branch whose target is the instruction's own address stops the core and raises a halted flag.

Top module: `sbn_core`

## Requirements
- R1: After reset, pc_o is 0, halted_o is 0 and retire_o is 0, and nothing executes until run_i is seen high.
- R2: The instruction at PC p is made of three words: mem[p] holds the destination address A, mem[p+1] holds the source address B and mem[p+2] holds the target C. Each address is the low ADDR_W bits of its word.
- R3: Executing an instruction replaces mem[A] with (mem[A] - mem[B]) mod 2^16.
- R4: If bit 15 of the difference is 1, the next PC is C. Otherwise the next PC is (p + 3) mod 2^ADDR_W.
- R5: Each instruction takes exactly six clocks. retire_o is high for one cycle per instruction, and pc_o shows the new PC in that same cycle. pc_o changes at no other time.
- R6: The sign is taken from the wrapped 16-bit difference. 0x8000 - 0x0001 = 0x7FFF does not branch. 0x7FFF - 0xFFFF = 0x8000 does branch.
- R7: When A equals B, the word becomes 0 and execution falls through.
- R8: A taken branch whose target C equals the instruction's own PC sets halted_o. halted_o then stays high, pc_o stays frozen, and no further memory writes occur. A not-taken instruction with C equal to its own PC does not halt.
- R9: A test write (tw_en_i) updates mem[tw_addr_i] only while the core is idle or halted. While the core is executing, a test write is ignored.
- R10: A result written by one instruction is visible to the fetches of every later instruction, so code can modify itself.
- R11: run_i is sampled only while the core is idle. While the core is executing or halted, run_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start execution from idle |
| tw_en_i | input | 1 | Test write enable |
| tw_addr_i | input | ADDR_W | Test write address |
| tw_data_i | input | DATA_W | Test write data |
| tr_addr_i | input | ADDR_W | Test read address |
| tr_data_o | output | DATA_W | Test read data (combinational) |
| pc_o | output | ADDR_W | Program counter |
| retire_o | output | 1 | One-cycle pulse when an instruction completes |
| halted_o | output | 1 | Core stopped on a self-targeted taken branch |

## Verification
Two behaviours can overlap. An instruction's result write can land on a word that the next instruction is about to fetch. A test write can arrive during the same cycle in which the core is executing. The first case is provoked by an instruction whose destination is the source field of the following instruction. The path that the following instruction then takes, and the final memory contents, show whether the new word was used. The second case is provoked by pulsing tw_en_i (and run_i) in the middle of execution; reading memory after the halt confirms that the write was dropped. A cycle-by-cycle reference model compares pc_o, retire_o and halted_o on every clock, and it also compares all of memory at the end of the run.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FA,
    ST_FB,
    ST_FC,
    ST_OPR,
    ST_WR,
    ST_UPD,
    ST_HALT
  } sbn_state_e;

  localparam int unsigned INSTR_WORDS = 3;
endpackage

// File: rtl/sbn_mem.sv
module sbn_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_RD   = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i [N_RD],
  output logic [DATA_W-1:0] rdata_o [N_RD]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/sbn_alu.sv
module sbn_alu #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] min_i,
  input  logic [DATA_W-1:0] sub_i,
  output logic [DATA_W-1:0] diff_o,
  output logic              neg_o
);
  assign diff_o = min_i - sub_i;
  assign neg_o  = diff_o[DATA_W-1];
endmodule

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
  import sbn_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DATA_W-1:0] rd_a_i,
  input  logic [DATA_W-1:0] rd_b_i,
  input  logic [DATA_W-1:0] diff_i,
  input  logic              neg_i,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] opb_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              tw_ok_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              retire_o,
  output logic              halted_o
);
  sbn_state_e        st_q, st_d;
  logic [ADDR_W-1:0] pc_q, dst_q, src_q, tgt_q;
  logic [DATA_W-1:0] opa_q, opb_q;
  logic              neg_q, retire_q, halted_q;
  logic              self_tgt;

  assign self_tgt = (tgt_q == pc_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (run_i) st_d = ST_FA;
      ST_FA:   st_d = ST_FB;
      ST_FB:   st_d = ST_FC;
      ST_FC:   st_d = ST_OPR;
      ST_OPR:  st_d = ST_WR;
      ST_WR:   st_d = ST_UPD;
      ST_UPD:  st_d = (neg_q && self_tgt) ? ST_HALT : ST_FA;
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_FB:   addr_a_o = pc_q + ADDR_W'(1);
      ST_FC:   addr_a_o = pc_q + ADDR_W'(2);
      ST_OPR:  addr_a_o = dst_q;
      default: addr_a_o = pc_q;
    endcase
  end

  assign addr_b_o = src_q;
  assign opa_o    = opa_q;
  assign opb_o    = opb_q;
  assign we_o     = (st_q == ST_WR);
  assign waddr_o  = dst_q;
  assign wdata_o  = diff_i;
  assign tw_ok_o  = (st_q == ST_IDLE) || (st_q == ST_HALT);
  assign pc_o     = pc_q;
  assign retire_o = retire_q;
  assign halted_o = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pc_q     <= RESET_PC;
      dst_q    <= '0;
      src_q    <= '0;
      tgt_q    <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      neg_q    <= 1'b0;
      retire_q <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      retire_q <= 1'b0;
      unique case (st_q)
        ST_FA:  dst_q <= rd_a_i[ADDR_W-1:0];
        ST_FB:  src_q <= rd_a_i[ADDR_W-1:0];
        ST_FC:  tgt_q <= rd_a_i[ADDR_W-1:0];
        ST_OPR: begin
          opa_q <= rd_a_i;
          opb_q <= rd_b_i;
        end
        ST_WR:  neg_q <= neg_i;
        ST_UPD: begin
          retire_q <= 1'b1;
          pc_q     <= neg_q ? tgt_q : pc_q + ADDR_W'(INSTR_WORDS);
          if (neg_q && self_tgt) halted_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbn_core.sv
module sbn_core #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tw_en_i,
  input  logic [ADDR_W-1:0] tw_addr_i,
  input  logic [DATA_W-1:0] tw_data_i,
  input  logic [ADDR_W-1:0] tr_addr_i,
  output logic [DATA_W-1:0] tr_data_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              retire_o,
  output logic              halted_o
);
  localparam int unsigned N_RD = 3;

  logic [ADDR_W-1:0] raddr [N_RD];
  logic [DATA_W-1:0] rdata [N_RD];
  logic [ADDR_W-1:0] addr_a, addr_b, core_waddr, mem_waddr;
  logic [DATA_W-1:0] opa, opb, diff, core_wdata, mem_wdata;
  logic              neg, core_we, tw_ok, tw_take, mem_we;

  assign raddr[0] = addr_a;
  assign raddr[1] = addr_b;
  assign raddr[2] = tr_addr_i;
  assign tr_data_o = rdata[2];

  // core and test writes are mutually exclusive by state
  assign tw_take   = tw_en_i && tw_ok;
  assign mem_we    = core_we || tw_take;
  assign mem_waddr = core_we ? core_waddr : tw_addr_i;
  assign mem_wdata = core_we ? core_wdata : tw_data_i;

  sbn_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_RD(N_RD)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  sbn_alu #(.DATA_W(DATA_W)) u_alu (
    .min_i (opa),
    .sub_i (opb),
    .diff_o(diff),
    .neg_o (neg)
  );

  sbn_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .rd_a_i  (rdata[0]),
    .rd_b_i  (rdata[1]),
    .diff_i  (diff),
    .neg_i   (neg),
    .addr_a_o(addr_a),
    .addr_b_o(addr_b),
    .opa_o   (opa),
    .opb_o   (opb),
    .we_o    (core_we),
    .waddr_o (core_waddr),
    .wdata_o (core_wdata),
    .tw_ok_o (tw_ok),
    .pc_o    (pc_o),
    .retire_o(retire_o),
    .halted_o(halted_o)
  );
endmodule

// File: rtl/sbn_chk.sv
module sbn_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] pc_i,
  input logic              retire_i,
  input logic              halted_i,
  input logic              core_we_i
);
  logic [2:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (retire_i) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 3'd7) begin
      gap_q <= gap_q + 3'd1;
    end
  end

  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  a_r8_halt_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(pc_i));

  a_r8_no_write_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !core_we_i);

  a_r5_pc_moves_on_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_i) |-> retire_i);

  a_r5_retire_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> !retire_i);

  a_r5_six_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && seen_q && !halted_i) |-> (gap_q == 3'd5));
endmodule

bind sbn_core sbn_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_i     (pc_o),
  .retire_i (retire_o),
  .halted_i (halted_o),
  .core_we_i(core_we)
);

// File: tb/sim_sbn_core.sv
module sim_sbn_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run;
  logic          tw_en;
  logic [AW-1:0] tw_addr;
  logic [DW-1:0] tw_data;
  logic [AW-1:0] tr_addr;
  logic [DW-1:0] tr_data;
  logic [AW-1:0] pc;
  logic          retire;
  logic          halted;

  sbn_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .tw_en_i(tw_en), .tw_addr_i(tw_addr), .tw_data_i(tw_data),
    .tr_addr_i(tr_addr), .tr_data_o(tr_data),
    .pc_o(pc), .retire_o(retire), .halted_o(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_pc;
  bit            m_run, m_halt, m_ret;
  int            m_cnt;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_exec();
    logic [AW-1:0] a, b, c;
    logic [DW-1:0] d;
    a = m_mem[m_pc][AW-1:0];
    b = m_mem[m_pc + AW'(1)][AW-1:0];
    c = m_mem[m_pc + AW'(2)][AW-1:0];
    d = m_mem[a] - m_mem[b];
    m_mem[a] = d;
    if (d[DW-1]) begin
      if (c == m_pc) begin
        m_halt = 1;
        m_run  = 0;
      end
      m_pc = c;
    end else begin
      m_pc = m_pc + AW'(3);
    end
  endtask

  task automatic m_edge();
    m_ret = 0;
    if (!rst_n) begin
      m_pc = '0; m_run = 0; m_halt = 0; m_cnt = 0;
    end else if (m_halt) begin
      if (tw_en) m_mem[tw_addr] = tw_data;
    end else if (!m_run) begin
      if (tw_en) m_mem[tw_addr] = tw_data;
      if (run) begin m_run = 1; m_cnt = 0; end
    end else begin
      m_cnt++;
      if (m_cnt == 6) begin
        m_exec();
        m_ret = 1;
        m_cnt = 0;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    m_edge();
    @(negedge clk);
    chk("R4 pc_o", int'(pc), int'(m_pc));
    chk("R5 retire_o", int'(retire), int'(m_ret));
    chk("R8 halted_o", int'(halted), int'(m_halt));
  endtask

  task automatic wr(int a, int d);
    tw_en = 1'b1; tw_addr = AW'(a); tw_data = DW'(d);
    step();
    tw_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    tr_addr = AW'(a);
    #1;
    chk(tag, int'(tr_data), exp);
  endtask

  task automatic instr(int at, int a, int b, int c);
    wr(at, a); wr(at + 1, b); wr(at + 2, c);
  endtask

  task automatic run_to_halt(bit poke);
    run = 1'b1;
    step();
    run = 1'b0;
    for (int i = 0; i < 2000 && !m_halt; i++) begin
      if (poke && i == 20) begin
        // R9: test write during execution must be dropped
        tw_en = 1'b1; tw_addr = 8'h8B; tw_data = 16'h1234;
      end
      if (poke && i == 31) run = 1'b1;  // R11: ignored while running
      step();
      tw_en = 1'b0;
      run = 1'b0;
    end
    chk("R8 reached halt", int'(m_halt), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; tw_en = 1'b0; tw_addr = '0; tw_data = '0; tr_addr = '0;
    m_pc = '0; m_run = 0; m_halt = 0; m_ret = 0; m_cnt = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset pc", int'(pc), 0);
    chk("R1 reset halted", int'(halted), 0);
    chk("R1 reset retire", int'(retire), 0);
    rst_n = 1'b1;

    for (int i = 0; i < DEPTH; i++) wr(i, 0);
    for (int i = 0; i < 4; i++) step();  // R1: idle, nothing runs
    chk("R1 idle pc", int'(pc), 0);

    // data
    wr(8'h80, 10);     wr(8'h81, 3);
    wr(8'h82, 16'h8000); wr(8'h83, 1);
    wr(8'h84, 16'h7FFF); wr(8'h85, 16'hFFFF);
    wr(8'h86, 0);      wr(8'h87, 1);
    wr(8'h88, 100);    wr(8'h89, 5);
    wr(8'h8A, 2);      wr(8'h8B, 16'h0055);
    // program (R2 layout: dest, src, target)
    instr(8'h00, 8'h80, 8'h81, 8'h40);  // R3 10-3, fall through
    instr(8'h03, 8'h82, 8'h83, 8'h40);  // R6 wrap, not negative
    instr(8'h06, 8'h84, 8'h85, 8'h10);  // R6 wrap, negative -> 0x10
    instr(8'h10, 8'h81, 8'h81, 8'h40);  // R7 A==B
    instr(8'h13, 8'h17, 8'h87, 8'h40);  // R10 patch next source field
    instr(8'h16, 8'h89, 8'h88, 8'h30);  // uses patched source
    instr(8'h19, 8'h8A, 8'h86, 8'h19);  // R8 not taken, self target
    instr(8'h1C, 8'h86, 8'h87, 8'h1C);  // R8 halt

    run_to_halt(1'b1);
    for (int i = 0; i < 8; i++) step();
    chk("R8 halt pc", int'(pc), 8'h1C);
    rd_chk("R3 mem80", 8'h80, 7);
    rd_chk("R6 mem82 no branch", 8'h82, 16'h7FFF);
    rd_chk("R6 mem84 branch", 8'h84, 16'h8000);
    rd_chk("R7 mem81 zero", 8'h81, 0);
    rd_chk("R10 patched word", 8'h17, 8'h87);
    rd_chk("R10 patched result", 8'h89, 4);
    rd_chk("R8 not-taken self target", 8'h8A, 2);
    rd_chk("R8 halting write", 8'h86, 16'hFFFF);
    rd_chk("R9 write ignored while running", 8'h8B, 16'h0055);
    wr(8'h8B, 16'h4321);
    rd_chk("R9 write accepted when halted", 8'h8B, 16'h4321);
    run = 1'b1; step(); run = 1'b0;
    chk("R11 run ignored when halted", int'(pc), 8'h1C);
    for (int i = 0; i < DEPTH; i++) rd_chk("R3 memory image", i, int'(m_mem[i]));

    // second program after a fresh reset
    rst_n = 1'b0;
    step();
    chk("R1 re-reset pc", int'(pc), 0);
    chk("R1 re-reset halted", int'(halted), 0);
    rst_n = 1'b1;
    wr(8'h90, 1); wr(8'h91, 2); wr(8'h92, 0); wr(8'h93, 5);
    instr(8'h00, 8'h90, 8'h91, 8'h20);  // R4 taken
    instr(8'h20, 8'h92, 8'h93, 8'h20);  // halt
    run_to_halt(1'b0);
    chk("R4 taken target pc", int'(pc), 8'h20);
    rd_chk("R3 negative result", 8'h90, 16'hFFFF);
    rd_chk("R3 halt result", 8'h92, 16'hFFFB);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule